// File: doc/BRIEF.md
# Trigger Condition Combiner with Cascade Handshake

This block turns a vector of per-probe comparator results into a single trigger event for a capture engine. A run-time mode input picks the reduction. In all-of mode every enabled comparator has to be satisfied in the same sample. In any-of mode one enabled comparator is enough. An enable mask takes comparators out of the reduction. A masked comparator does not block an all-of match and cannot cause an any-of match.

Two optional cascade paths let analyzers trigger one another. An incoming cascade trigger is edge-detected, ORed with the local condition, and acknowledged with a one-cycle pulse. An outgoing cascade trigger rises with each event and holds until the receiver acknowledges it. Each path is enabled by its own build parameter, and both default to off.

After an event the block disarms itself. It produces no further events until the capture engine re-arms it.

Top module: `trigger_combiner`

## Requirements
- R1: With `mode_any_i` = 0 (all-of), a sample in which every bit set in `enable_i` has its `match_i` bit set, and `enable_i` is non-zero, produces `event_o` high in the following cycle while armed. A single enabled bit that does not match produces no event.
- R2: With `mode_any_i` = 1 (any-of), a sample in which at least one bit is set in both `match_i` and `enable_i` produces `event_o` high in the following cycle while armed. Otherwise there is no event.
- R3: A `match_i` bit whose `enable_i` bit is 0 has no effect on the result in either mode. When `enable_i` is all zero, no local event is ever produced.
- R4: `event_o` is a single-cycle pulse. After an event the block is disarmed and ignores all trigger sources. A cycle with `arm_i` high re-arms the block for the next sampled cycle. The block comes out of reset armed.
- R5: When enabled, `cascade_out` rises in the same cycle as `event_o`. It stays high until `cascade_out_ack` is sampled high, falls in the next cycle, and does not rise again before a re-arm and a new event.
- R6: When enabled, a rising edge on `cascade_in` is a trigger source ORed with the local condition. A rising edge is high in this sample and low in the previous one. A level held high does not trigger again.
- R7: When enabled, `cascade_in_ack` is high for exactly one cycle, the cycle after a rising edge of `cascade_in` is sampled. This happens whether the block is armed or not.
- R8: With the input cascade path disabled, `cascade_in` has no effect and `cascade_in_ack` stays 0. With the output cascade path disabled, `cascade_out` stays 0.
- R9: While `rst_n` is low, `event_o`, `cascade_out` and `cascade_in_ack` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Active-low synchronous reset |
| match_i | input | NUM_PROBES | Per-probe comparator results |
| enable_i | input | NUM_PROBES | Comparator enable mask |
| mode_any_i | input | 1 | 0 = all-of reduction, 1 = any-of reduction |
| arm_i | input | 1 | Re-arms the block after an event |
| cascade_in | input | 1 | Trigger from a neighbouring analyzer |
| cascade_in_ack | output | 1 | One-cycle acknowledge of a cascade_in edge |
| cascade_out | output | 1 | Trigger to a neighbouring analyzer, held until acknowledged |
| cascade_out_ack | input | 1 | Acknowledge of cascade_out |
| event_o | output | 1 | Registered one-cycle trigger event |

## Verification
The bench sweeps every mask, match value and mode on a four-probe build. This exposes a design that counts masked comparators, and one that fires all-of on an empty mask because the empty AND is vacuously true. Directed sequences cover the following failure modes:
- an output that keeps firing while the match condition persists, which shows a missing disarm;
- a cascade output that drops before its acknowledge, or rises again without a re-arm;
- a held `cascade_in` level that retriggers, or an acknowledge that is stretched or suppressed while disarmed.

A second instance built with the default parameters must stay silent on both cascade pins.

// File: rtl/trigc_pkg.sv
package trigc_pkg;

    typedef struct packed {
        logic armed;
        logic fired;
    } core_state_t;

    typedef struct packed {
        logic prev;
        logic ack;
    } cin_state_t;

    typedef struct packed {
        logic level;
    } cout_state_t;

endpackage

// File: rtl/trigc_reduce.sv
module trigc_reduce #(
    parameter int NUM_PROBES = 8
) (
    input  logic [NUM_PROBES-1:0] match_i,
    input  logic [NUM_PROBES-1:0] enable_i,
    input  logic                  mode_any_i,
    output logic                  hit_o
);
    logic all_ok;
    logic any_hit;
    logic mask_live;

    always_comb begin
        all_ok  = 1'b1;
        any_hit = 1'b0;
        for (int i = 0; i < NUM_PROBES; i++) begin
            if (enable_i[i]) begin
                if (!match_i[i]) all_ok = 1'b0;
                if (match_i[i])  any_hit = 1'b1;
            end
        end
        mask_live = |enable_i;
        // An empty mask must never fire: guard the vacuous all-of result.
        hit_o = mode_any_i ? any_hit : (all_ok & mask_live);
    end
endmodule

// File: rtl/trigc_cascade_in.sv
module trigc_cascade_in
    import trigc_pkg::*;
#(
    parameter bit ENABLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic ack_o
);
    generate
        if (ENABLE) begin : g_on
            cin_state_t st_d, st_q;

            always_comb begin
                st_d      = st_q;
                rise_o    = level_i & ~st_q.prev;
                st_d.prev = level_i;
                st_d.ack  = rise_o;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign ack_o = st_q.ack;
        end else begin : g_off
            logic [2:0] unused_pins;
            assign unused_pins = {clk, rst_n, level_i};
            assign rise_o = 1'b0;
            assign ack_o  = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/trigc_cascade_out.sv
module trigc_cascade_out
    import trigc_pkg::*;
#(
    parameter bit ENABLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic ack_i,
    output logic level_o
);
    generate
        if (ENABLE) begin : g_on
            cout_state_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (fire_i)                  st_d.level = 1'b1;
                else if (st_q.level && ack_i) st_d.level = 1'b0;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign level_o = st_q.level;
        end else begin : g_off
            logic [3:0] unused_pins;
            assign unused_pins = {clk, rst_n, fire_i, ack_i};
            assign level_o = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/trigger_combiner.sv
module trigger_combiner
    import trigc_pkg::*;
#(
    parameter int NUM_PROBES     = 8,
    parameter bit CASCADE_IN_EN  = 1'b0,
    parameter bit CASCADE_OUT_EN = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PROBES-1:0] match_i,
    input  logic [NUM_PROBES-1:0] enable_i,
    input  logic                  mode_any_i,
    input  logic                  arm_i,
    input  logic                  cascade_in,
    output logic                  cascade_in_ack,
    output logic                  cascade_out,
    input  logic                  cascade_out_ack,
    output logic                  event_o
);
    logic        local_hit;
    logic        remote_rise;
    logic        fire;
    core_state_t core_d, core_q;

    trigc_reduce #(.NUM_PROBES(NUM_PROBES)) u_reduce (
        .match_i    (match_i),
        .enable_i   (enable_i),
        .mode_any_i (mode_any_i),
        .hit_o      (local_hit)
    );

    trigc_cascade_in #(.ENABLE(CASCADE_IN_EN)) u_cin (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (cascade_in),
        .rise_o  (remote_rise),
        .ack_o   (cascade_in_ack)
    );

    always_comb begin
        core_d       = core_q;
        fire         = core_q.armed & (local_hit | remote_rise);
        core_d.fired = fire;
        // Re-arm wins over disarm so a held arm keeps the block live.
        if (arm_i)     core_d.armed = 1'b1;
        else if (fire) core_d.armed = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) core_q <= '{armed: 1'b1, fired: 1'b0};
        else        core_q <= core_d;
    end

    assign event_o = core_q.fired;

    trigc_cascade_out #(.ENABLE(CASCADE_OUT_EN)) u_cout (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (fire),
        .ack_i   (cascade_out_ack),
        .level_o (cascade_out)
    );
endmodule

// File: rtl/trigger_combiner_chk.sv
module trigger_combiner_chk #(
    parameter int NUM_PROBES     = 8,
    parameter bit CASCADE_OUT_EN = 1'b0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_PROBES-1:0] match_i,
    input logic [NUM_PROBES-1:0] enable_i,
    input logic                  mode_any_i,
    input logic                  arm_i,
    input logic                  cascade_in,
    input logic                  cascade_in_ack,
    input logic                  cascade_out,
    input logic                  cascade_out_ack,
    input logic                  event_o
);
    AST_AND_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_any_i && |(enable_i & ~match_i) && !cascade_in) |=> !event_o); // R1

    AST_OR_NOHIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_any_i && ((match_i & enable_i) == '0) && !cascade_in) |=> !event_o); // R2

    AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ((enable_i == '0) && !cascade_in) |=> !event_o); // R3

    AST_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o && !$past(arm_i)) |=> !event_o); // R4

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade_out && !cascade_out_ack) |=> cascade_out); // R5

    AST_OUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade_out && cascade_out_ack) |=> (!cascade_out || event_o)); // R5

    AST_IN_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cascade_in_ack |-> $past(cascade_in)); // R7

    AST_IN_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cascade_in_ack |=> !cascade_in_ack); // R7

    generate
        if (CASCADE_OUT_EN) begin : g_out
            AST_OUT_WITH_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
                event_o |-> cascade_out); // R5
        end
    endgenerate
endmodule

bind trigger_combiner trigger_combiner_chk #(
    .NUM_PROBES     (NUM_PROBES),
    .CASCADE_OUT_EN (CASCADE_OUT_EN)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .match_i         (match_i),
    .enable_i        (enable_i),
    .mode_any_i      (mode_any_i),
    .arm_i           (arm_i),
    .cascade_in      (cascade_in),
    .cascade_in_ack  (cascade_in_ack),
    .cascade_out     (cascade_out),
    .cascade_out_ack (cascade_out_ack),
    .event_o         (event_o)
);

// File: tb/trigger_combiner_test.sv
`timescale 1ns/1ps
module trigger_combiner_test;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] match, en;
    logic         mode_any, arm, cin, oack;
    logic         ev, cin_ack, cout;
    logic         ev_d, cin_ack_d, cout_d;
    int           checks = 0;
    int           fails = 0;

    always #10 clk = ~clk;

    trigger_combiner #(.NUM_PROBES(N), .CASCADE_IN_EN(1'b1), .CASCADE_OUT_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .match_i(match), .enable_i(en), .mode_any_i(mode_any),
        .arm_i(arm), .cascade_in(cin), .cascade_in_ack(cin_ack), .cascade_out(cout),
        .cascade_out_ack(oack), .event_o(ev));

    trigger_combiner #(.NUM_PROBES(N)) dflt (
        .clk(clk), .rst_n(rst_n), .match_i(match), .enable_i(en), .mode_any_i(mode_any),
        .arm_i(arm), .cascade_in(cin), .cascade_in_ack(cin_ack_d), .cascade_out(cout_d),
        .cascade_out_ack(oack), .event_o(ev_d));

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    function automatic logic expect_hit(input logic [N-1:0] m, input logic [N-1:0] e,
                                        input logic any);
        if (any) return |(m & e);
        return (e != '0) && ((m & e) == e);
    endfunction

    initial begin
        match = '0; en = '0; mode_any = 1'b0; arm = 1'b0; cin = 1'b0; oack = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 event in reset", ev, 1'b0);
        chk("R9 cascade_out in reset", cout, 1'b0);
        chk("R9 cascade_in_ack in reset", cin_ack, 1'b0);
        rst_n = 1'b1;

        // Exhaustive reduction sweep, kept armed and acknowledged.
        arm = 1'b1; oack = 1'b1;
        for (int md = 0; md < 2; md++) begin
            for (int e = 0; e < 16; e++) begin
                for (int m = 0; m < 16; m++) begin
                    logic exp;
                    string tag;
                    match = m[N-1:0]; en = e[N-1:0]; mode_any = md[0];
                    exp = expect_hit(m[N-1:0], e[N-1:0], md[0]);
                    tag = (e == 0) ? "R3" : (md == 1) ? "R2" : "R1";
                    @(negedge clk);
                    chk(tag, ev, exp);
                    chk("R5 out follows event", cout, exp);
                    chk("R8 default build event", ev_d, exp);
                end
            end
        end

        // Disarm, hold and re-arm.
        arm = 1'b0; oack = 1'b0; mode_any = 1'b1; en = 4'b0001; match = 4'b0001;
        @(negedge clk);
        chk("R4 first event", ev, 1'b1);
        chk("R5 out rises", cout, 1'b1);
        chk("R8 default out stays low", cout_d, 1'b0);
        @(negedge clk);
        chk("R4 pulse ends, disarmed", ev, 1'b0);
        chk("R5 out held", cout, 1'b1);
        repeat (3) begin
            @(negedge clk);
            chk("R4 no event while disarmed", ev, 1'b0);
            chk("R5 out held without ack", cout, 1'b1);
        end
        oack = 1'b1;
        @(negedge clk);
        chk("R5 out drops after ack", cout, 1'b0);
        oack = 1'b0;
        @(negedge clk);
        chk("R5 no re-rise before re-arm", cout, 1'b0);
        chk("R4 still disarmed", ev, 1'b0);
        arm = 1'b1;
        @(negedge clk);
        chk("R4 re-arm cycle has no event", ev, 1'b0);
        arm = 1'b0;
        @(negedge clk);
        chk("R4 event after re-arm", ev, 1'b1);
        chk("R5 out after re-arm", cout, 1'b1);
        oack = 1'b1;
        @(negedge clk);
        chk("R5 out drops again", cout, 1'b0);
        oack = 1'b0;

        // Cascade input edges with no local source.
        match = '0; en = '0; mode_any = 1'b0; arm = 1'b1; oack = 1'b1;
        @(negedge clk);
        chk("R3 idle, empty mask", ev, 1'b0);
        cin = 1'b1;
        @(negedge clk);
        chk("R6 rising cascade_in fires", ev, 1'b1);
        chk("R7 ack pulse", cin_ack, 1'b1);
        chk("R8 default ignores cascade_in", ev_d, 1'b0);
        chk("R8 default ack stays low", cin_ack_d, 1'b0);
        @(negedge clk);
        chk("R6 held level no retrigger", ev, 1'b0);
        chk("R7 ack one cycle only", cin_ack, 1'b0);
        cin = 1'b0; arm = 1'b0;
        @(negedge clk);
        chk("R6 low level no event", ev, 1'b0);
        cin = 1'b1;
        @(negedge clk);
        chk("R6 second edge fires", ev, 1'b1);
        cin = 1'b0;
        @(negedge clk);
        cin = 1'b1;
        @(negedge clk);
        chk("R4 disarmed ignores cascade_in", ev, 1'b0);
        chk("R7 ack while disarmed", cin_ack, 1'b1);
        cin = 1'b0;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule